// File: doc/BRIEF.md
# BCD calendar time counter

This block keeps the time of day and the calendar in seven packed-BCD byte registers. Each register holds the tens digit in its upper nibble. The registers are seconds, minutes, hours, date, month, two-digit year and day of week. A clock enable arrives at the crystal rate, and a prescaler divides it down to one carry per second. The carry ripples through the registers. The count follows the month lengths, takes every year divisible by four as a leap year, and lets the hour register run in either 24-hour or 12-hour form.

Software-side logic reaches the block through a byte write port and a byte read port. A write takes effect only while the permission input is high. After a reset, which stands for total supply loss, the counter stays frozen until the first accepted write. A read request copies all seven registers at once into a holding buffer. The read port then serves bytes from that copy, so a second boundary cannot tear a multi-byte read. A 3-bit trim code shortens or lengthens one second per trim interval by a few prescaler counts.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. Each wraps to 00 and passes a carry to the next register.
- R2: In 24-hour mode (hour bit 7 = 0), hours run 00 to 23. After 23 the hour wraps to 00 and advances the day. Day of week (register 6) counts 0 to 6 and wraps to 0 at midnight.
- R3: In 12-hour mode (hour bit 7 = 1), the hour register is {1, 0, PM, tens bit, units}, with PM in bit 5. The sequence is 12 to 01 with PM unchanged, and 11 to 12 with PM toggled. The day advances only when 11 PM turns into 12 AM.
- R4: The date wraps to 01 after the last day of its month. That last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on 29 when the year is divisible by 4, and on 28 otherwise.
- R5: After the last day of month 12, the month becomes 01 and the year advances. Year 99 wraps to 00.
- R6: Reset clears all registers and the read data to 00. The counter does not advance, whatever the clock enable does, until one write has been accepted.
- R7: A write with the permission input low changes no register and does not start the counter.
- R8: An accepted write stores the byte, masked to the field's width, and restarts the prescaler at zero. When a write falls in the same cycle as a second carry, the written value wins and that carry is lost.
- R9: A read request copies all seven live registers into the buffer at that clock edge. Read data is the buffered byte selected by the read address, registered one cycle later. The buffer keeps its contents until the next read request.
- R10: With no trim, a second ends after exactly PRESCALE clock enables counted from the last accepted write.
- R11: The trim code is a sign (bit 2) and a magnitude (bits 1:0). In the last second of every TRIM_PERIOD_S seconds, that second lasts PRESCALE minus the magnitude enables when the sign is 0, or PRESCALE plus the magnitude enables when the sign is 1.
- R12: Address 7 reads as 00. Writes to address 7 are ignored and do not restart the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (supply loss) |
| tick_en | input | 1 | One-cycle enable at the crystal rate |
| wr_unlock | input | 1 | Write permission for the time registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address for the write |
| wr_data | input | 8 | BCD byte to write |
| rd_req | input | 1 | Capture all live registers into the read buffer |
| rd_addr | input | 3 | Register address for the read |
| trim_code | input | 3 | Rate trim: bit 2 sign, bits 1:0 magnitude |
| rd_data | output | 8 | Registered byte from the read buffer |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a register write and the second carry. The bench drives a write on exactly the clock enable that closes a second, and expects the written value to hold and the following second to last a full PRESCALE enables. The second pair is a buffer capture and an increment. The bench issues a read request and then runs the counter across a boundary. It expects the buffer to show the pre-increment time until the next request. A behavioural model runs alongside the block and checks the read data on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int N_REGS = 7;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC = 3'd0, A_MIN = 3'd1, A_HOUR = 3'd2, A_DATE = 3'd3,
    A_MONTH = 3'd4, A_YEAR = 3'd5, A_DOW = 3'd6, A_NONE = 3'd7
  } reg_addr_e;

  // BCD increment of a two-digit byte; callers handle wrap limits.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Year divisible by four: tens even with units 0/4/8, tens odd with units 2/6.
  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4] == 1'b0) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mo, input logic leap);
    case (mo)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(input logic [ADDR_W-1:0] a);
    case (a)
      A_SEC, A_MIN: return 8'h7F;
      A_HOUR:       return 8'hBF;
      A_DATE:       return 8'h3F;
      A_MONTH:      return 8'h1F;
      A_YEAR:       return 8'hFF;
      A_DOW:        return 8'h07;
      default:      return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE      = 32768,
  parameter int TRIM_PERIOD_S = 2,
  parameter int TRIM_W        = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic              tick_en,
  input  logic [TRIM_W-1:0] trim_code,
  output logic              sec_pulse
);
  localparam int MAG_MAX = (1 << (TRIM_W - 1)) - 1;
  localparam int CW      = $clog2(PRESCALE + MAG_MAX + 1);
  localparam int SW      = (TRIM_PERIOD_S > 1) ? $clog2(TRIM_PERIOD_S) : 1;

  logic [CW-1:0] cnt_q, limit, mag;
  logic [SW-1:0] sidx_q;
  logic          trim_now, at_limit;

  always_comb begin
    trim_now = (sidx_q == SW'(TRIM_PERIOD_S - 1));
    mag      = CW'(trim_code[TRIM_W-2:0]);
    limit    = CW'(PRESCALE - 1);
    if (trim_now) limit = trim_code[TRIM_W-1] ? (limit + mag) : (limit - mag);
    at_limit  = (cnt_q == limit);
    sec_pulse = run && tick_en && at_limit && !restart;
  end

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt_q  <= '0;
      sidx_q <= '0;
    end else if (tick_en) begin
      if (at_limit) begin
        cnt_q  <= '0;
        sidx_q <= trim_now ? '0 : sidx_q + SW'(1);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(PRESCALE - 1 + MAG_MAX));
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0) && (sidx_q == '0));
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sec_pulse,
  input  logic                    wr_acc,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  output logic                    running,
  output logic [N_REGS-1:0][7:0]  time_q
);
  logic [N_REGS-1:0][7:0] nxt;
  logic c_min, c_hour, c_day, c_mon, c_year, pm;
  logic [7:0] hv;

  always_comb begin
    nxt    = time_q;
    c_min  = 1'b0;
    c_hour = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_year = 1'b0;
    pm     = time_q[A_HOUR][5];
    hv     = 8'h00;
    // seconds
    if (time_q[A_SEC] == 8'h59) begin
      nxt[A_SEC] = 8'h00;
      c_min      = 1'b1;
    end else nxt[A_SEC] = bcd_inc(time_q[A_SEC]);
    // minutes
    if (c_min) begin
      if (time_q[A_MIN] == 8'h59) begin
        nxt[A_MIN] = 8'h00;
        c_hour     = 1'b1;
      end else nxt[A_MIN] = bcd_inc(time_q[A_MIN]);
    end
    // hours
    if (c_hour) begin
      if (time_q[A_HOUR][7]) begin
        hv = {3'b000, time_q[A_HOUR][4:0]};
        if (hv == 8'h12) nxt[A_HOUR] = {2'b10, pm, 5'h01};
        else if (hv == 8'h11) begin
          nxt[A_HOUR] = {2'b10, ~pm, 5'h12};
          c_day       = pm;
        end else nxt[A_HOUR] = {2'b10, pm, bcd_inc(hv)[4:0]};
      end else begin
        hv = {2'b00, time_q[A_HOUR][5:0]};
        if (hv == 8'h23) begin
          nxt[A_HOUR] = 8'h00;
          c_day       = 1'b1;
        end else nxt[A_HOUR] = {2'b00, bcd_inc(hv)[5:0]};
      end
    end
    // day of week and date
    if (c_day) begin
      nxt[A_DOW] = (time_q[A_DOW] == 8'h06) ? 8'h00 : time_q[A_DOW] + 8'h01;
      if (time_q[A_DATE] == last_day(time_q[A_MONTH], is_leap(time_q[A_YEAR]))) begin
        nxt[A_DATE] = 8'h01;
        c_mon       = 1'b1;
      end else nxt[A_DATE] = bcd_inc(time_q[A_DATE]);
    end
    // month and year
    if (c_mon) begin
      if (time_q[A_MONTH] == 8'h12) begin
        nxt[A_MONTH] = 8'h01;
        c_year       = 1'b1;
      end else nxt[A_MONTH] = bcd_inc(time_q[A_MONTH]);
    end
    if (c_year) nxt[A_YEAR] = (time_q[A_YEAR] == 8'h99) ? 8'h00 : bcd_inc(time_q[A_YEAR]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q  <= '0;
      running <= 1'b0;
    end else if (wr_acc) begin
      time_q[wr_addr] <= wr_data & field_mask(wr_addr);
      running         <= 1'b1;
    end else if (running && sec_pulse) begin
      time_q <= nxt;
    end
  end

  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (!running && !wr_acc) |=> $stable(time_q));
  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (running && sec_pulse && !wr_acc && time_q[A_SEC] == 8'h59) |=> (time_q[A_SEC] == 8'h00));
  p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && wr_addr == A_SEC) |=> (time_q[A_SEC] == ($past(wr_data) & 8'h7F)));
  p_dow_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (running && !wr_acc && time_q[A_DOW] == 8'h06 && $changed(time_q[A_DOW])) |-> $past(time_q[A_DOW]) == 8'h05);
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cap,
  input  logic [N_REGS-1:0][7:0] live,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_data
);
  logic [N_REGS-1:0][7:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      rd_data <= 8'h00;
    end else begin
      if (cap) snap_q <= live;
      rd_data <= (int'(rd_addr) < N_REGS) ? snap_q[rd_addr] : 8'h00;
    end
  end

  p_snap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(snap_q));
  p_snap_take_r9: assert property (@(posedge clk) disable iff (rst)
    cap |=> (snap_q == $past(live)));
  p_hole_reads_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_NONE) |=> (rd_data == 8'h00));
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE      = 32768,
  parameter int TRIM_PERIOD_S = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_unlock,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [2:0]        trim_code,
  output logic [7:0]        rd_data
);
  logic                   wr_acc, running, sec_pulse;
  logic [N_REGS-1:0][7:0] live;

  assign wr_acc = wr_en && wr_unlock && (int'(wr_addr) < N_REGS);

  rtc_prescaler #(.PRESCALE(PRESCALE), .TRIM_PERIOD_S(TRIM_PERIOD_S), .TRIM_W(3)) u_pre (
    .clk(clk), .rst(rst), .run(running), .restart(wr_acc),
    .tick_en(tick_en), .trim_code(trim_code), .sec_pulse(sec_pulse)
  );

  rtc_time_chain u_chain (
    .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .wr_acc(wr_acc),
    .wr_addr(wr_addr), .wr_data(wr_data), .running(running), .time_q(live)
  );

  rtc_snapshot u_snap (
    .clk(clk), .rst(rst), .cap(rd_req), .live(live),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  p_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_unlock && !running) |=> $stable(live) && !running);
endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
  localparam int PS = 4;
  localparam int TP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1, tick_en = 1'b0, wr_unlock = 1'b0, wr_en = 1'b0, rd_req = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0, trim_code = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string phase = "R6";

  int m_live[7], m_snap[7];
  int m_rd = 0, m_run = 0, m_cnt = 0, m_sidx = 0;

  always #5 clk = ~clk;

  rtc_calendar_core #(.PRESCALE(PS), .TRIM_PERIOD_S(TP)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_unlock(wr_unlock), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .trim_code(trim_code), .rd_data(rd_data)
  );

  function automatic int b2i(int v); return (v >> 4) * 10 + (v & 15); endfunction
  function automatic int i2b(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int fmask(int a);
    case (a)
      0, 1: return 'h7F;
      2: return 'hBF;
      3: return 'h3F;
      4: return 'h1F;
      5: return 'hFF;
      6: return 'h07;
      default: return 0;
    endcase
  endfunction

  task automatic model_advance();
    int s, mi, h, pm, dc, d, mo, y, days;
    dc = 0;
    s = b2i(m_live[0]);
    if (s != 59) begin m_live[0] = i2b(s + 1); return; end
    m_live[0] = 0;
    mi = b2i(m_live[1]);
    if (mi != 59) begin m_live[1] = i2b(mi + 1); return; end
    m_live[1] = 0;
    if ((m_live[2] & 'h80) != 0) begin
      pm = (m_live[2] >> 5) & 1;
      h = b2i(m_live[2] & 'h1F);
      if (h == 12) h = 1;
      else if (h == 11) begin h = 12; dc = pm; pm = 1 - pm; end
      else h = h + 1;
      m_live[2] = 'h80 | (pm << 5) | i2b(h);
    end else begin
      h = b2i(m_live[2] & 'h3F);
      if (h == 23) begin h = 0; dc = 1; end else h = h + 1;
      m_live[2] = i2b(h);
    end
    if (dc == 0) return;
    m_live[6] = (m_live[6] == 6) ? 0 : m_live[6] + 1;
    mo = b2i(m_live[4]);
    y = b2i(m_live[5]);
    if (mo == 2) days = (y % 4 == 0) ? 29 : 28;
    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) days = 30;
    else days = 31;
    d = b2i(m_live[3]);
    if (d < days) begin m_live[3] = i2b(d + 1); return; end
    m_live[3] = 1;
    if (mo != 12) begin m_live[4] = i2b(mo + 1); return; end
    m_live[4] = 1;
    m_live[5] = i2b((y + 1) % 100);
  endtask

  // Reference model, updated on the same edge as the design.
  always @(posedge clk) begin
    int nrd, lim, mag;
    if (rst) begin
      for (int i = 0; i < 7; i++) begin m_live[i] = 0; m_snap[i] = 0; end
      m_rd = 0; m_run = 0; m_cnt = 0; m_sidx = 0;
    end else begin
      nrd = (rd_addr < 7) ? m_snap[rd_addr] : 0;
      if (rd_req) for (int i = 0; i < 7; i++) m_snap[i] = m_live[i];
      m_rd = nrd;
      if (wr_en && wr_unlock && wr_addr < 7) begin
        m_live[wr_addr] = wr_data & fmask(int'(wr_addr));
        m_run = 1; m_cnt = 0; m_sidx = 0;
      end else if (m_run != 0 && tick_en) begin
        lim = PS - 1;
        mag = int'(trim_code[1:0]);
        if (m_sidx == TP - 1) lim = trim_code[2] ? lim + mag : lim - mag;
        if (m_cnt == lim) begin
          m_cnt = 0;
          m_sidx = (m_sidx + 1) % TP;
          model_advance();
        end else m_cnt = m_cnt + 1;
      end
    end
  end

  // Every-cycle comparison and watchdog.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      n_cmp++;
      if (rd_data !== m_rd[7:0]) begin
        n_bad++;
        $display("FAIL %s: cycle compare rd_data=%02h expected %02h", phase, rd_data, m_rd[7:0]);
      end
    end
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected under 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick_en = 1'b1; @(negedge clk); end
    tick_en = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic set_time(logic [7:0] hr, logic [7:0] dt, logic [7:0] mo, logic [7:0] yr);
    wr(3'd2, hr); wr(3'd3, dt); wr(3'd4, mo); wr(3'd5, yr);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R6 reset state
    phase = "R6";
    for (int a = 0; a < 7; a++) begin rd(3'(a), v); check("R6 reset value", v, 8'h00); end
    ticks(20);
    rd(3'd0, v); check("R6 frozen before first write", v, 8'h00);
    // R7 locked write
    phase = "R7";
    wr(3'd0, 8'h30);
    ticks(10);
    rd(3'd0, v); check("R7 locked write ignored", v, 8'h00);
    // R2/R4 leap February, midnight
    phase = "R4";
    wr_unlock = 1'b1;
    wr(3'd6, 8'h06);
    set_time(8'h23, 8'h28, 8'h02, 8'h24);
    wr(3'd0, 8'h58);
    ticks(8);
    rd(3'd3, v); check("R4 leap Feb 28->29", v, 8'h29);
    rd(3'd6, v); check("R2 day of week 6->0", v, 8'h00);
    rd(3'd2, v); check("R2 hour 23->00", v, 8'h00);
    rd(3'd1, v); check("R1 minute 59->00", v, 8'h00);
    rd(3'd0, v); check("R1 seconds 58->00", v, 8'h00);
    set_time(8'h23, 8'h28, 8'h02, 8'h23);
    ticks(4);
    rd(3'd3, v); check("R4 common Feb 28->Mar 1 date", v, 8'h01);
    rd(3'd4, v); check("R4 common Feb 28->Mar 1 month", v, 8'h03);
    set_time(8'h23, 8'h30, 8'h04, 8'h23);
    ticks(4);
    rd(3'd4, v); check("R4 Apr 30 -> May", v, 8'h05);
    // R5 year end
    phase = "R5";
    set_time(8'h23, 8'h31, 8'h12, 8'h99);
    ticks(4);
    rd(3'd4, v); check("R5 month 12->01", v, 8'h01);
    rd(3'd5, v); check("R5 year 99->00", v, 8'h00);
    // R3 12-hour mode
    phase = "R3";
    set_time(8'h91, 8'h01, 8'h01, 8'h00);
    ticks(4);
    rd(3'd2, v); check("R3 11AM->12PM", v, 8'hB2);
    set_time(8'hB2, 8'h01, 8'h01, 8'h00);
    ticks(4);
    rd(3'd2, v); check("R3 12PM->01PM", v, 8'hA1);
    set_time(8'hB1, 8'h01, 8'h01, 8'h00);
    ticks(4);
    rd(3'd2, v); check("R3 11PM->12AM", v, 8'h92);
    rd(3'd3, v); check("R3 day advances at 12AM", v, 8'h02);
    // R11 trim
    phase = "R11";
    trim_code = 3'b010;
    wr(3'd0, 8'h00);
    ticks(6);
    rd(3'd0, v); check("R11 fast trim two seconds in 6 enables", v, 8'h02);
    trim_code = 3'b110;
    wr(3'd0, 8'h00);
    ticks(9);
    rd(3'd0, v); check("R11 slow trim one second after 9 enables", v, 8'h01);
    ticks(1);
    rd(3'd0, v); check("R11 slow trim second second after 10", v, 8'h02);
    trim_code = 3'b000;
    // R8/R10 write colliding with a second carry
    phase = "R8";
    wr(3'd0, 8'h10);
    ticks(3);
    tick_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h20;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    ticks(3);
    rd(3'd0, v); check("R8 write wins over carry", v, 8'h20);
    ticks(1);
    rd(3'd0, v); check("R10 full second after restart", v, 8'h21);
    // R9 snapshot coherence
    phase = "R9";
    rd(3'd0, v);
    ticks(4);
    rd_addr = 3'd1; @(negedge clk); rd_addr = 3'd0; @(negedge clk);
    check("R9 buffer holds old value", rd_data, 8'h21);
    rd(3'd0, v); check("R9 new capture", v, 8'h22);
    // R12 hole address
    phase = "R12";
    rd(3'd7, v); check("R12 address 7 reads 00", v, 8'h00);
    ticks(2);
    wr(3'd7, 8'hFF);
    ticks(2);
    rd(3'd0, v); check("R12 write to 7 leaves prescaler running", v, 8'h23);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule